// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Start Detection

This block receives NRZ serial frames on a single line. Each frame has a low start bit, eight data bits sent least significant bit first, and one stop bit. A baud strobe at sixteen times the bit rate drives the bit timing. The timing restarts at the falling edge of every start bit. Each bit is decided by a two-out-of-three vote over oversampling ticks 7, 8 and 9. A finished frame goes into a receive data register, which raises a ready flag. A frame that finishes while the ready flag is still set also raises an overrun flag. A low stop bit raises a sticky framing flag.

A build-time parameter selects one of two start-detection styles. The level style treats a low line as a start. It also remembers a falling edge seen while reception is disabled. As a result, reception begins at once when the enable rises, if the line is low or such an edge is pending. The edge style only starts on a falling edge that occurs while reception is enabled. It keeps nothing across a disabled period.

Dropping the enable never cuts a frame short. The frame in progress finishes and is stored. The soft-reset input aborts any frame, forgets a pending start and clears the data and flags.

The receiver is a four-state machine:
- IDLE waits for a start request.
- START checks the start bit. A high vote drops it as a glitch (START to IDLE). Otherwise START moves to DATA at the end of the start bit.
- DATA stays in DATA for each of the eight bits, then moves to STOP after the last one.
- STOP returns to IDLE at the stop-bit vote and reports the frame.
- Soft reset forces any state to IDLE.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_data` is 0 and `data_rdy`, `overrun` and `frame_err` are 0.
- R2: A frame is a low start bit, 8 data bits LSB first (bit 0 of `rx_data` is the first data bit on the line) and a stop bit, each lasting 16 `baud_tick` strobes. When the frame completes, `rx_data` holds the data byte and `data_rdy` is 1. This holds in both detection styles.
- R3: Bit timing restarts at the falling edge of each start bit, so back-to-back frames with no idle gap are each received correctly. Every bit is the majority of the line samples at ticks 7, 8 and 9 of that bit.
- R4: A start whose vote is high is dropped as a glitch. It stores no data, and the next proper frame is received normally.
- R5: A low stop bit sets `frame_err` (1 = framing error), and the byte is still stored with `data_rdy` set. `frame_err` stays set until `err_clr` or `soft_rst`.
- R6: A one-cycle `rd_stb` clears `data_rdy` and leaves `overrun` and `frame_err` unchanged.
- R7: A frame that completes while `data_rdy` is 1 sets `overrun`, and its byte replaces the old one in `rx_data`.
- R8: `err_clr` clears `overrun` and `frame_err`. A frame completing in the same cycle wins.
- R9: If `rx_en` falls in the middle of a frame, that frame is completed and stored. Frames sent while `rx_en` is 0 are not received.
- R10: Level style (`START_MODE` = level): raising `rx_en` while the line is low, or after a falling edge seen while disabled, starts reception at once. A frame whose start bit began before the enable is therefore received.
- R11: Edge style (`START_MODE` = edge): raising `rx_en` while the line is low does not start reception, and no start is kept across a disabled period. Only a falling edge while enabled starts a frame.
- R12: `soft_rst` aborts a frame in progress, returns the receiver to IDLE, forgets a pending start, and clears `rx_data`, `data_rdy`, `overrun` and `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high, asynchronous to `clk` |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Synchronous receiver reset |
| rd_stb | input | 1 | Read strobe, clears `data_rdy` |
| err_clr | input | 1 | Clears `overrun` and `frame_err` |
| rx_data | output | 8 | Receive data register |
| data_rdy | output | 1 | Unread data present |
| overrun | output | 1 | Sticky: a frame was stored over unread data |
| frame_err | output | 1 | Sticky: a frame had a low stop bit |

## Verification
The assertions assume that `baud_tick`, `rd_stb`, `err_clr` and `soft_rst` are single-cycle strobes synchronous to `clk`. They also assume the serial line holds each bit for a full sixteen ticks. The stimulus produces one tick every fourth clock and holds each bit for 64 clocks. It keeps the line high between frames and pulses every strobe for exactly one clock. A second receiver built with the edge style shares the same stimulus, so every frame also checks the difference between the two styles.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_EDGE  = 1'b1
    } det_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign dout = chain[STAGES-1];
    assign fall = last & ~chain[STAGES-1];

endmodule

// File: rtl/srx_start_det.sv
module srx_start_det
    import srx_pkg::*;
#(
    parameter det_mode_e MODE = DET_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic en,
    input  logic idle,
    input  logic line,
    input  logic fall,
    output logic start_req
);
    generate
        if (MODE == DET_LEVEL) begin : g_level
            logic pend;

            assign start_req = idle & en & (pend | ~line);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend <= 1'b0;
                end else if (soft_rst) begin
                    pend <= 1'b0;
                end else if (start_req) begin
                    pend <= 1'b0;
                end else if (idle && !en && fall) begin
                    pend <= 1'b1;
                end
            end

            // R10: a start seen while disabled stays pending until used or reset
            a_r10_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (pend && !en && !soft_rst) |=> pend);
        end else begin : g_edge
            assign start_req = idle & en & fall;

            // R11: an enabled, idle receiver with a steady line never starts
            a_r11_no_level_start: assert property (@(posedge clk) disable iff (!rst_n)
                (idle && en && !line && !fall) |-> !start_req);
        end
    endgenerate

endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 start_req,
    output logic                 idle,
    output logic                 done,
    output logic                 frm_ok,
    output logic [DATA_BITS-1:0] data
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] SMP_A    = CNT_W'(OSR / 2 - 2);
    localparam logic [CNT_W-1:0] SMP_B    = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] SMP_V    = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_e            state, state_nx;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic                 s_a, s_b;
    logic [DATA_BITS-1:0] shreg;
    logic                 at_a, at_b, at_vote, at_end, vote;

    assign at_a    = tick && (cnt == SMP_A);
    assign at_b    = tick && (cnt == SMP_B);
    assign at_vote = tick && (cnt == SMP_V);
    assign at_end  = tick && (cnt == CNT_LAST);
    assign vote    = maj3(s_a, s_b, line);
    assign idle    = (state == ST_IDLE);
    assign data    = shreg;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_req) state_nx = ST_START;
            ST_START: begin
                if (at_vote && vote)   state_nx = ST_IDLE;
                else if (at_end)       state_nx = ST_DATA;
            end
            ST_DATA:  if (at_end && idx == IDX_LAST) state_nx = ST_STOP;
            ST_STOP:  if (at_vote) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (soft_rst) state <= ST_IDLE;
        else               state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            idx    <= '0;
            s_a    <= 1'b1;
            s_b    <= 1'b1;
            shreg  <= '0;
            done   <= 1'b0;
            frm_ok <= 1'b1;
        end else begin
            done <= (state == ST_STOP) && at_vote && !soft_rst;
            if (at_vote) frm_ok <= vote;
            if (at_a)    s_a <= line;
            if (at_b)    s_b <= line;
            if (soft_rst || state == ST_IDLE) begin
                cnt <= '0;
                idx <= '0;
            end else if (tick) begin
                cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
                if (state == ST_DATA && at_end) idx <= idx + 1'b1;
            end
            if (state == ST_DATA && at_vote) shreg <= {vote, shreg[DATA_BITS-1:1]};
        end
    end

    // R3: a frame is only reported one cycle after a mid-bit baud strobe
    a_r3_vote_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick));
    // R2: completion is a single-cycle event
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: a start rejected by the vote returns straight to idle
    a_r4_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && at_vote && vote && !soft_rst) |=> (state == ST_IDLE && !done));
    // R12: soft reset leaves the machine idle with no report
    a_r12_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state == ST_IDLE && !done));

endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import srx_pkg::*;
#(
    parameter det_mode_e START_MODE  = DET_LEVEL,
    parameter int        OSR         = 16,
    parameter int        DATA_BITS   = 8,
    parameter int        SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_in,
    input  logic                 baud_tick,
    input  logic                 rx_en,
    input  logic                 soft_rst,
    input  logic                 rd_stb,
    input  logic                 err_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 data_rdy,
    output logic                 overrun,
    output logic                 frame_err
);
    logic                 line, fall, start_req, idle, done, frm_ok;
    logic [DATA_BITS-1:0] frm_data;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (line),
        .fall (fall)
    );

    srx_start_det #(.MODE(START_MODE)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .en       (rx_en),
        .idle     (idle),
        .line     (line),
        .fall     (fall),
        .start_req(start_req)
    );

    srx_fsm #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .tick     (baud_tick),
        .line     (line),
        .start_req(start_req),
        .idle     (idle),
        .done     (done),
        .frm_ok   (frm_ok),
        .data     (frm_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            data_rdy  <= 1'b0;
            overrun   <= 1'b0;
            frame_err <= 1'b0;
        end else if (soft_rst) begin
            rx_data   <= '0;
            data_rdy  <= 1'b0;
            overrun   <= 1'b0;
            frame_err <= 1'b0;
        end else if (done) begin
            rx_data   <= frm_data;
            data_rdy  <= 1'b1;
            overrun   <= data_rdy | (overrun & ~err_clr);
            frame_err <= ~frm_ok | (frame_err & ~err_clr);
        end else begin
            if (rd_stb) data_rdy <= 1'b0;
            if (err_clr) begin
                overrun   <= 1'b0;
                frame_err <= 1'b0;
            end
        end
    end

    // R2: a completed frame always leaves data ready
    a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !soft_rst) |=> data_rdy);
    // R7: completion over unread data raises overrun
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (done && data_rdy && !soft_rst) |=> overrun);
    // R6: a read with no competing completion empties the register
    a_r6_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done && !soft_rst) |=> !data_rdy);
    // R5: the framing flag only moves on completion, clear or soft reset
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !err_clr && !soft_rst) |=> $stable(frame_err));
    // R12: soft reset empties data and flags
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!data_rdy && !overrun && !frame_err && rx_data == '0));
    // R9: with the enable low and the receiver idle, nothing new is stored
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && idle) |=> !done);

endmodule

// File: tb/serial_rx_tb.sv
module serial_rx_tb;
    import srx_pkg::*;

    localparam int BIT = 64;   // 16 ticks x 4 clocks
    localparam int GAP = 80;
    localparam logic [8:0] VEC [0:5] = '{9'h1A5, 9'h100, 9'h03C, 9'h1FF, 9'h081, 9'h16E};

    logic clk = 1'b0;
    logic rst_n, rx_in, baud_tick, rx_en, soft_rst, rd_stb, err_clr;
    logic [7:0] lv_data, eg_data;
    logic lv_rdy, lv_ovr, lv_ferr, eg_rdy, eg_ovr, eg_ferr;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    serial_rx #(.START_MODE(DET_LEVEL)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .rx_en(rx_en), .soft_rst(soft_rst), .rd_stb(rd_stb), .err_clr(err_clr),
        .rx_data(lv_data), .data_rdy(lv_rdy), .overrun(lv_ovr), .frame_err(lv_ferr)
    );

    serial_rx #(.START_MODE(DET_EDGE)) u_dut_edge (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .rx_en(rx_en), .soft_rst(soft_rst), .rd_stb(rd_stb), .err_clr(err_clr),
        .rx_data(eg_data), .data_rdy(eg_rdy), .overrun(eg_ovr), .frame_err(eg_ferr)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop);
        rx_in = 1'b0;
        wait_clk(BIT);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            wait_clk(BIT);
        end
        rx_in = stop;
        wait_clk(BIT);
        rx_in = 1'b1;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        wait_clk(1);
        s = 1'b0;
        wait_clk(1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (3) @(posedge clk);
            #1 baud_tick = 1'b1;
            @(posedge clk);
            #1 baud_tick = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..R12 run): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_in = 1'b1; rx_en = 1'b0;
        soft_rst = 1'b0; rd_stb = 1'b0; err_clr = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        chk("R1 rx_data", {lv_data, eg_data}, 16'h0);
        chk("R1 data_rdy", {lv_rdy, eg_rdy}, 2'b00);
        chk("R1 overrun", {lv_ovr, eg_ovr}, 2'b00);
        chk("R1 frame_err", {lv_ferr, eg_ferr}, 2'b00);

        rx_en = 1'b1;
        wait_clk(GAP);
        // R2/R5 vector table
        for (int v = 0; v < 6; v++) begin
            send_frame(VEC[v][7:0], VEC[v][8]);
            wait_clk(GAP);
            chk("R2 level data", lv_data, VEC[v][7:0]);
            chk("R2 edge data", eg_data, VEC[v][7:0]);
            chk("R2 data_rdy", {lv_rdy, eg_rdy}, 2'b11);
            chk("R5 frame_err", {lv_ferr, eg_ferr}, {2{~VEC[v][8]}});
            pulse(rd_stb);
            chk("R6 read clears rdy", {lv_rdy, eg_rdy}, 2'b00);
            chk("R6 read keeps frame_err", {lv_ferr, eg_ferr}, {2{~VEC[v][8]}});
            pulse(err_clr);
            chk("R8 err_clr frame_err", {lv_ferr, eg_ferr}, 2'b00);
        end

        // R4 glitch start
        rx_in = 1'b0;
        wait_clk(12);
        rx_in = 1'b1;
        wait_clk(120);
        chk("R4 glitch no data", {lv_rdy, eg_rdy}, 2'b00);
        send_frame(8'h3C, 1'b1);
        wait_clk(GAP);
        chk("R4 after glitch level", lv_data, 8'h3C);
        chk("R4 after glitch edge", eg_data, 8'h3C);
        pulse(rd_stb);

        // R3/R7 back-to-back frames, overrun
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1);
        wait_clk(GAP);
        chk("R3 back-to-back level", lv_data, 8'h34);
        chk("R3 back-to-back edge", eg_data, 8'h34);
        chk("R7 overrun", {lv_ovr, eg_ovr}, 2'b11);
        pulse(rd_stb);
        chk("R6 read keeps overrun", {lv_ovr, eg_ovr, lv_rdy, eg_rdy}, 4'b1100);
        pulse(err_clr);
        chk("R8 err_clr overrun", {lv_ovr, eg_ovr}, 2'b00);

        // R9 disable mid-frame
        fork
            send_frame(8'h96, 1'b1);
            begin
                wait_clk(4 * BIT);
                rx_en = 1'b0;
            end
        join
        wait_clk(GAP);
        chk("R9 finished level", lv_data, 8'h96);
        chk("R9 finished edge", eg_data, 8'h96);
        chk("R9 finished rdy", {lv_rdy, eg_rdy}, 2'b11);
        pulse(rd_stb);
        send_frame(8'h55, 1'b1);
        wait_clk(GAP);
        chk("R9 disabled ignored", {lv_rdy, eg_rdy}, 2'b00);
        pulse(soft_rst);

        // R10/R11 enable while the start bit is already low
        rx_in = 1'b0;
        wait_clk(16);
        rx_en = 1'b1;
        wait_clk(BIT - 16);
        for (int i = 0; i < 9; i++) begin
            rx_in = 1'b1;
            wait_clk(BIT);
        end
        wait_clk(GAP);
        chk("R10 level starts at enable", lv_rdy, 1'b1);
        chk("R10 level data", lv_data, 8'hFF);
        chk("R11 edge needs fresh edge", eg_rdy, 1'b0);

        // R12 soft reset mid-frame
        fork
            send_frame(8'hF0, 1'b1);
            begin
                wait_clk(6 * BIT + 8);
                pulse(soft_rst);
            end
        join
        wait_clk(GAP);
        chk("R12 aborted rdy", {lv_rdy, eg_rdy}, 2'b00);
        chk("R12 cleared data", {lv_data, eg_data}, 16'h0);
        send_frame(8'hC3, 1'b1);
        wait_clk(GAP);
        chk("R12 resumes level", lv_data, 8'hC3);
        chk("R12 resumes edge", eg_data, 8'hC3);

        summary();
        $finish;
    end

endmodule